// File: doc/BRIEF.md
# Full-Bridge PWM Direction Steering

This block generates a pulse-width-modulated waveform from its own prescaled timebase and routes it onto the four gate outputs of an H-bridge: A, B, C and D. In the forward direction, A is held on and D carries the modulation. In reverse, C is held on and B carries it. B and D form the modulated pair. A and C form the unmodulated pair. No dead-band is inserted between outputs.

The direction request may change at any clock, but the bridge changes direction only at a period boundary. When the sampled request differs from the current direction, a changeover window opens in the last 4 × prescale clocks of the period. During that window A and C already show the new direction's pattern, while B and D are held low. The next period then starts with the new direction. Duty, period and prescale select are captured only at a period boundary, so a write in the middle of a period cannot produce a glitch.

Top module: `hbridge_dir_steer`

## Requirements
- R1: When no changeover is in progress, forward drives out_a=1, out_c=0, out_b=0 and out_d equal to the PWM. Reverse drives out_c=1, out_a=0, out_d=0 and out_b equal to the PWM. On dir_req, 0 means forward and 1 means reverse.
- R2: A new direction is applied only from the first clock of the next period. Before the changeover window, a request change leaves all four outputs unchanged.
- R3: When the sampled request differs from the active direction, the changeover covers the final 4 × prescale clocks of the period. In those clocks out_b and out_d are 0, and out_a/out_c show the pattern of the requested direction.
- R4: ps_sel 2'b00 selects a prescale of 1, 2'b01 selects 4, and 2'b10 or 2'b11 selects 16. The count advances once every prescale clocks and wraps to 0 after reaching the period value. A period therefore lasts (period+1) × prescale clocks.
- R5: The PWM is high while the count is below the captured duty. A duty of 0 gives no pulse, and a duty above the period value keeps the modulated output high for the whole period, window excepted.
- R6: Duty, period and prescale select are captured at the period boundary. A write in the middle of a period does not affect that period.
- R7: When the sampled request equals the active direction, no changeover happens, and the modulated output keeps following the PWM through the end of the period.
- R8: out_a and out_c are never 1 in the same clock.
- R9: During reset and until the first period begins, all outputs are 0 and the direction is forward. The first period begins one clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_req | input | 1 | Requested direction: 0 forward, 1 reverse |
| ps_sel | input | 2 | Timebase prescale select |
| duty | input | CW | Duty value in count units |
| period | input | CW | Last count value of a period |
| out_a | output | 1 | High-side gate, forward leg |
| out_b | output | 1 | Modulated gate, reverse leg |
| out_c | output | 1 | High-side gate, reverse leg |
| out_d | output | 1 | Modulated gate, forward leg |

## Verification
The four outputs are decoded without a register from state, so they settle in the same clock that the state changes. A dir_req change passes through one sampling register and can open the changeover window from the next clock on. Duty, period and prescale writes appear only in the clock after the next boundary. The bench drives inputs and samples outputs on the falling edge, and compares each output every clock against a period-position model that it advances on the rising edge. The window-length checks count falling edges from the rise of C to the first pulse on B, expecting 4 × prescale.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  localparam int PS_W = 5;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;

  // prescale factor from the 2-bit select: 1, 4 or 16
  function automatic logic [PS_W-1:0] ps_factor(input logic [1:0] sel);
    if (sel[1])      return PS_W'(16);
    else if (sel[0]) return PS_W'(4);
    else             return PS_W'(1);
  endfunction

  // clocks left in the period, current clock included, is at most 4*prescale
  function automatic logic in_window(input logic [31:0] cnt, input logic [31:0] pre,
                                     input logic [31:0] per, input logic [31:0] ps);
    logic [31:0] left;
    left = (per - cnt) * ps + (ps - pre);
    return left <= (ps << 2);
  endfunction

endpackage

// File: rtl/hbs_timebase.sv
module hbs_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ps_sel,
  input  logic [CW-1:0] per_in,
  output logic [CW-1:0] cnt,
  output logic          bound,
  output logic          win,
  output logic          started
);
  import hbs_pkg::*;

  logic [PS_W-1:0] ps_act, pre_cnt;
  logic [CW-1:0]   per_act, cnt_q;
  logic            started_q;
  logic            tick;

  assign tick  = (pre_cnt == ps_act - PS_W'(1));
  assign bound = tick && (cnt_q == per_act);
  assign win   = in_window(32'(cnt_q), 32'(pre_cnt), 32'(per_act), 32'(ps_act));
  assign cnt     = cnt_q;
  assign started = started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_act    <= PS_W'(1);
      pre_cnt   <= '0;
      per_act   <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (bound) begin
      pre_cnt   <= '0;
      cnt_q     <= '0;
      per_act   <= per_in;
      ps_act    <= ps_factor(ps_sel);
      started_q <= 1'b1;
    end else if (tick) begin
      pre_cnt <= '0;
      cnt_q   <= cnt_q + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_act);
  assert_pre_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt < ps_act);
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bound |=> (cnt_q == '0 && pre_cnt == '0));
  assert_timing_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bound |=> ($stable(per_act) && $stable(ps_act)));

endmodule

// File: rtl/hbs_pwm.sv
module hbs_pwm #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bound,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] cnt,
  output logic          pwm
);
  logic [CW-1:0] duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     duty_act <= '0;
    else if (bound) duty_act <= duty_in;
  end

  assign pwm = (cnt < duty_act);

  assert_duty_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bound |=> $stable(duty_act));

endmodule

// File: rtl/hbs_dir_ctrl.sv
module hbs_dir_ctrl (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_req,
  input  logic          win,
  input  logic          bound,
  output hbs_pkg::dir_e active_dir,
  output hbs_pkg::dir_e drive_dir,
  output logic          sw_active
);
  import hbs_pkg::*;

  dir_e pend_q, act_q, tgt_q, tgt;
  logic sw_q, sw_start;

  assign sw_start  = win && (pend_q != act_q);
  assign sw_active = sw_q || sw_start;
  assign tgt       = sw_q ? tgt_q : pend_q;
  assign drive_dir = sw_active ? tgt : act_q;
  assign active_dir = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= DIR_FWD;
      act_q  <= DIR_FWD;
      tgt_q  <= DIR_FWD;
      sw_q   <= 1'b0;
    end else begin
      pend_q <= dir_e'(dir_req);
      tgt_q  <= tgt;
      if (bound) begin
        act_q <= drive_dir;
        sw_q  <= 1'b0;
      end else begin
        sw_q  <= sw_active;
      end
    end
  end

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bound |=> $stable(act_q));
  assert_target_differs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |-> (tgt_q != act_q));

endmodule

// File: rtl/hbridge_dir_steer.sv
module hbridge_dir_steer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_req,
  input  logic [1:0]    ps_sel,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] period,
  output logic          out_a,
  output logic          out_b,
  output logic          out_c,
  output logic          out_d
);
  import hbs_pkg::*;

  logic [CW-1:0] cnt;
  logic          bound, win, started, pwm, sw_active;
  dir_e          active_dir, drive_dir;

  hbs_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .ps_sel(ps_sel), .per_in(period),
    .cnt(cnt), .bound(bound), .win(win), .started(started)
  );

  hbs_pwm #(.CW(CW)) u_pwm (
    .clk(clk), .rst_n(rst_n), .bound(bound), .duty_in(duty),
    .cnt(cnt), .pwm(pwm)
  );

  hbs_dir_ctrl u_dir (
    .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .win(win), .bound(bound),
    .active_dir(active_dir), .drive_dir(drive_dir), .sw_active(sw_active)
  );

  assign out_a = started && (drive_dir == DIR_FWD);
  assign out_c = started && (drive_dir == DIR_REV);
  assign out_b = started && !sw_active && (active_dir == DIR_REV) && pwm;
  assign out_d = started && !sw_active && (active_dir == DIR_FWD) && pwm;

  assert_ac_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_c));
  assert_bd_off_in_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_active |-> (!out_b && !out_d));
  assert_steady_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !sw_active) |-> (out_a == (active_dir == DIR_FWD)));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !(out_a || out_b || out_c || out_d));

endmodule

// File: tb/tb_hbridge_dir_steer.sv
module tb_hbridge_dir_steer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_req = 1'b0;
  logic [1:0] ps_sel = 2'b00;
  logic [7:0] duty = 8'd3;
  logic [7:0] period = 8'd3;
  logic       out_a, out_b, out_c, out_d;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic cmp_en = 1'b0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  hbridge_dir_steer #(.CW(8)) dut (
    .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .ps_sel(ps_sel),
    .duty(duty), .period(period),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] ps_of(input logic [1:0] s);
    case (s)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // position-in-period reference model
  logic [15:0] m_k, m_L;
  logic [4:0]  m_ps;
  logic [7:0]  m_duty;
  logic m_pend, m_act, m_sw, m_tgt, m_started;
  logic m_last, m_win, e_sw, e_tgt, e_drv, e_pwm;

  always_comb begin
    m_last = (m_k == m_L - 16'd1);
    m_win  = (int'(m_k) >= int'(m_L) - 4 * int'(m_ps));
    e_sw   = m_sw | (m_win & (m_pend != m_act));
    e_tgt  = m_sw ? m_tgt : m_pend;
    e_drv  = e_sw ? e_tgt : m_act;
    e_pwm  = (int'(m_k) / int'(m_ps)) < int'(m_duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k <= '0; m_L <= 16'd1; m_ps <= 5'd1; m_duty <= '0;
      m_pend <= 1'b0; m_act <= 1'b0; m_sw <= 1'b0; m_tgt <= 1'b0; m_started <= 1'b0;
    end else begin
      m_pend <= dir_req;
      if (m_last) begin
        m_k <= '0;
        m_L <= (16'(period) + 16'd1) * 16'(ps_of(ps_sel));
        m_ps <= ps_of(ps_sel);
        m_duty <= duty;
        m_started <= 1'b1;
        m_act <= e_drv;
        m_sw <= 1'b0;
      end else begin
        m_k <= m_k + 16'd1;
        m_sw <= e_sw;
        m_tgt <= e_tgt;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(e_sw ? "R3" : cur_tag, "out_a", 32'(out_a), 32'(m_started & ~e_drv));
      chk(e_sw ? "R3" : cur_tag, "out_c", 32'(out_c), 32'(m_started & e_drv));
      chk(e_sw ? "R3" : cur_tag, "out_b", 32'(out_b), 32'(m_started & ~e_sw & m_act & e_pwm));
      chk(e_sw ? "R3" : cur_tag, "out_d", 32'(out_d), 32'(m_started & ~e_sw & ~m_act & e_pwm));
      chk("R8", "a_and_c", 32'(out_a & out_c), 32'd0);
    end
  end

  // {dir, ps_sel, duty, period, cycles}
  localparam int NV = 9;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 2'b00, 8'd3,   8'd7, 12'd40},
    {1'b0, 2'b01, 8'd5,   8'd9, 12'd120},
    {1'b1, 2'b00, 8'd2,   8'd5, 12'd30},
    {1'b1, 2'b10, 8'd4,   8'd3, 12'd200},
    {1'b0, 2'b01, 8'd0,   8'd4, 12'd60},
    {1'b0, 2'b00, 8'd255, 8'd6, 12'd30},
    {1'b1, 2'b00, 8'd7,   8'd7, 12'd30},
    {1'b1, 2'b00, 8'd1,   8'd2, 12'd30},
    {1'b0, 2'b11, 8'd2,   8'd1, 12'd100}
  };
  localparam string VTAG [NV] = '{"R1", "R4", "R2", "R4", "R5", "R5", "R1", "R7", "R3"};

  task automatic wait_rise(input logic use_b);
    logic prev, cur;
    prev = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cur = use_b ? out_b : out_d;
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic window_len(input logic [1:0] sel, input logic [7:0] dt, input int exp_len);
    int n;
    dir_req = 1'b0; ps_sel = sel; period = 8'd9; duty = dt;
    repeat (400) @(negedge clk);
    wait_rise(1'b0);
    dir_req = 1'b1;
    n = 0;
    while (!out_c && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!out_b && n < 2000);
    chk("R3", "window_clocks", 32'(n), 32'(exp_len));
  endtask

  initial begin
    int hi;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "outs_in_reset", {28'd0, out_a, out_b, out_c, out_d}, 32'd0);
    rst_n = 1'b1;
    chk("R9", "outs_before_first_edge", {28'd0, out_a, out_b, out_c, out_d}, 32'd0);
    @(negedge clk);
    chk("R9", "a_after_start", 32'(out_a), 32'd1);
    chk("R9", "d_after_start", 32'(out_d), 32'd1);
    cmp_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      cur_tag = VTAG[v];
      {dir_req, ps_sel, duty, period} = VEC[v][30:12];
      repeat (int'(VEC[v][11:0])) @(negedge clk);
    end

    // R2: request early in the period leaves outputs alone
    cur_tag = "R2";
    dir_req = 1'b0; ps_sel = 2'b00; period = 8'd9; duty = 8'd5;
    repeat (60) @(negedge clk);
    wait_rise(1'b0);
    dir_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "a_held", 32'(out_a), 32'd1);
      chk("R2", "c_held", 32'(out_c), 32'd0);
    end

    // R3 and R4: window length for prescale 4 and 16
    cur_tag = "R3";
    window_len(2'b01, 8'd5, 16);
    window_len(2'b10, 8'd3, 64);

    // R6: duty write mid-period does not affect that period
    cur_tag = "R6";
    dir_req = 1'b0; ps_sel = 2'b00; period = 8'd9; duty = 8'd2;
    repeat (400) @(negedge clk);
    wait_rise(1'b0);
    hi = 1;
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      if (i == 4) duty = 8'd8;
      hi += int'(out_d);
    end
    chk("R6", "d_high_old_duty", 32'(hi), 32'd2);
    hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); hi += int'(out_d); end
    chk("R6", "d_high_new_duty", 32'(hi), 32'd8);

    // R7: same-direction request keeps modulation through window
    cur_tag = "R7";
    duty = 8'd255;
    repeat (40) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); hi += int'(out_d & ~out_b); end
    chk("R7", "d_full_run", 32'(hi), 32'd30);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule